// File: doc/BRIEF.md
# Video beam position counter

This block tracks the beam position of a tile-based video display processor. An 8-bit horizontal slot counter advances once for each access slot, which the surrounding design signals with a clock enable. A 9-bit line counter advances once per line. Two horizontal modes are supported. The wide mode has 40 cells and the narrow mode has 32. In each mode the slot counter jumps over a fixed range of values. The line counter steps at a slot in the middle of the line, not when the slot counter wraps.

From the two counters the block produces several outputs. It drives the horizontal-blank and vertical-blank status bits. It runs a horizontal interrupt countdown that is reloaded each line and emits a one-cycle pulse when it expires. It provides a 16-bit position word that software can read. This word can be frozen at a captured value, and in double-resolution interlace mode its line byte is re-encoded. The video standard (NTSC or PAL) sets the frame length and the first inactive line. The block uses a copy of the standard bit that is refreshed only at the very start of a frame.

Top module: `beam_pos_counter`

## Requirements
- R1: After reset `hpos`, `vpos`, `hint_pulse` and `hv_word` are 0. With `slot_en` low, `hpos` and `vpos` hold. With `slot_en` high, `hpos` advances by one modulo 256, except for the jumps in R2 and R3.
- R2: In wide mode (`wide_mode`=1), a slot step that would produce 183 produces 229 instead. Values 183 to 228 are never entered.
- R3: In narrow mode (`wide_mode`=0), a slot step that would produce 148 produces 233 instead.
- R4: `vpos` advances on the slot step that enters slot 165 (wide) or slot 132 (narrow), and on no other step. It returns to 0 after line 261 when the latched standard is NTSC, or after line 312 when it is PAL.
- R5: `hblank` is 1 exactly when `hpos` is above 178 in wide mode, or above 233 in narrow mode.
- R6: `vblank` is 1 when `disp_en` is 0. It is also 1 when `vpos` is at least the first inactive line and below 511. The first inactive line is 224 for NTSC and 240 for PAL, chosen by the latched standard.
- R7: On the line-step slot, the countdown is updated using the line being entered. If that line is inactive, the countdown is reloaded from `hint_reload`. Otherwise a nonzero countdown decrements by one. A zero countdown is reloaded and `hint_pulse` is 1 for the following single clock. The countdown is 0 after reset.
- R8: The latched standard takes `pal_mode` only on a slot step taken while `hpos`=0 and `vpos`=0. It is NTSC (0) after reset.
- R9: The live position word is {line byte, `hpos`}, with the line byte in bits 15:8. A clock with `hv_capture`=1 stores the live word. While `hv_freeze`=1, `hv_word` shows the stored word; otherwise it shows the live word.
- R10: With `dbl_interlace`=0 the line byte is `vpos`[7:0]. With `dbl_interlace`=1 it is {`vpos`[6:0], `vpos`[7]}, that is, the line shifted left by one with the bit shifted out placed in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_en | input | 1 | One access slot elapses this clock |
| wide_mode | input | 1 | 1 = 40-cell mode, 0 = 32-cell mode |
| pal_mode | input | 1 | 1 = PAL standard requested, 0 = NTSC |
| disp_en | input | 1 | Display enable |
| dbl_interlace | input | 1 | Double-resolution interlace line encoding |
| hv_freeze | input | 1 | Show the captured position word |
| hv_capture | input | 1 | Store the live position word this clock |
| hint_reload | input | 8 | Horizontal interrupt countdown reload value |
| hpos | output | 8 | Horizontal slot counter |
| vpos | output | 9 | Line counter |
| hblank | output | 1 | Horizontal blank status |
| vblank | output | 1 | Vertical blank status |
| hint_pulse | output | 1 | One-clock horizontal interrupt pulse |
| hv_word | output | 16 | Position readout |

## Verification
A wrong slot value appears on `hpos` one clock after the faulty step. Through the line-step and blank decodes it then spreads to `vpos`, `hblank` and `hint_pulse`. A wrong line count or wrong latched standard may not show until a frame boundary: the frame then wraps at the wrong line, or `vblank` rises at the wrong line. For that reason the stimulus includes complete frames in both standards. A countdown error shows as a `hint_pulse` on the wrong line. This can take as many lines as the reload value before it appears, so the reload values used include small ones and zero.

// File: rtl/beam_pos_counter.sv
module beam_pos_counter #(
  parameter logic [7:0] WIDE_JUMP_FROM   = 8'd183,
  parameter logic [7:0] WIDE_JUMP_TO     = 8'd229,
  parameter logic [7:0] NARROW_JUMP_FROM = 8'd148,
  parameter logic [7:0] NARROW_JUMP_TO   = 8'd233,
  parameter logic [7:0] WIDE_LINE_SLOT   = 8'd165,
  parameter logic [7:0] NARROW_LINE_SLOT = 8'd132,
  parameter logic [7:0] WIDE_HBL_START   = 8'd178,
  parameter logic [7:0] NARROW_HBL_START = 8'd233,
  parameter logic [8:0] NTSC_LINES       = 9'd262,
  parameter logic [8:0] PAL_LINES        = 9'd313,
  parameter logic [8:0] NTSC_INACTIVE    = 9'd224,
  parameter logic [8:0] PAL_INACTIVE     = 9'd240
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slot_en,
  input  logic        wide_mode,
  input  logic        pal_mode,
  input  logic        disp_en,
  input  logic        dbl_interlace,
  input  logic        hv_freeze,
  input  logic        hv_capture,
  input  logic [7:0]  hint_reload,
  output logic [7:0]  hpos,
  output logic [8:0]  vpos,
  output logic        hblank,
  output logic        vblank,
  output logic        hint_pulse,
  output logic [15:0] hv_word
);

  logic [7:0]  h_q;
  logic [8:0]  v_q;
  logic        pal_q;
  logic [7:0]  cnt_q;
  logic        pulse_q;
  logic [15:0] cap_q;

  logic [7:0]  h_inc, h_nxt;
  logic        line_step;
  logic [8:0]  v_last, v_nxt, inact;
  logic [7:0]  line_byte;
  logic [15:0] live_word;

  assign h_inc = h_q + 8'd1;

  always_comb begin
    h_nxt = h_inc;
    if (wide_mode && h_inc == WIDE_JUMP_FROM) h_nxt = WIDE_JUMP_TO;
    if (!wide_mode && h_inc == NARROW_JUMP_FROM) h_nxt = NARROW_JUMP_TO;
  end

  assign line_step = h_nxt == (wide_mode ? WIDE_LINE_SLOT : NARROW_LINE_SLOT);
  assign v_last    = pal_q ? PAL_LINES - 9'd1 : NTSC_LINES - 9'd1;
  assign inact     = pal_q ? PAL_INACTIVE : NTSC_INACTIVE;
  assign v_nxt     = !line_step ? v_q : (v_q == v_last ? 9'd0 : v_q + 9'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_q     <= '0;
      v_q     <= '0;
      pal_q   <= 1'b0;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
      cap_q   <= '0;
    end else begin
      pulse_q <= 1'b0;
      if (hv_capture) cap_q <= live_word;
      if (slot_en) begin
        h_q <= h_nxt;
        v_q <= v_nxt;
        if (h_q == 8'd0 && v_q == 9'd0) pal_q <= pal_mode;
        if (line_step) begin
          if (v_nxt >= inact) begin
            cnt_q <= hint_reload;
          end else if (cnt_q != 8'd0) begin
            cnt_q <= cnt_q - 8'd1;
          end else begin
            cnt_q   <= hint_reload;
            pulse_q <= 1'b1;
          end
        end
      end
    end
  end

  assign line_byte = dbl_interlace ? {v_q[6:0], v_q[7]} : v_q[7:0];
  assign live_word = {line_byte, h_q};

  assign hpos       = h_q;
  assign vpos       = v_q;
  assign hblank     = h_q > (wide_mode ? WIDE_HBL_START : NARROW_HBL_START);
  assign vblank     = !disp_en || (v_q >= inact && v_q < 9'h1FF);
  assign hint_pulse = pulse_q;
  assign hv_word    = hv_freeze ? cap_q : live_word;

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_en |=> ($stable(hpos) && $stable(vpos)));

  assert_wide_skip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_en && wide_mode && hpos == 8'd182) |=> hpos == 8'd229);

  assert_narrow_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_en && !wide_mode && hpos == 8'd147) |=> hpos == 8'd233);

  assert_line_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vpos) |-> (hpos == 8'd165 || hpos == 8'd132));

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hint_pulse |=> !hint_pulse);

  assert_pal_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_en || hpos != 8'd0 || vpos != 9'd0) |=> $stable(pal_q));

  assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hv_freeze && !hv_capture) |=> (!hv_freeze || $stable(hv_word)));

endmodule

// File: tb/beam_pos_counter_tb.sv
`timescale 1ns/1ps
module beam_pos_counter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slot_en = 1'b0, wide_mode = 1'b1, pal_mode = 1'b0, disp_en = 1'b1;
  logic dbl_interlace = 1'b0, hv_freeze = 1'b0, hv_capture = 1'b0;
  logic [7:0] hint_reload = 8'd20;
  logic [7:0] hpos;
  logic [8:0] vpos;
  logic hblank, vblank, hint_pulse;
  logic [15:0] hv_word;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  logic [7:0] m_h = 8'd0;
  logic [8:0] m_v = 9'd0;
  logic m_pal = 1'b0;
  logic [7:0] m_cnt = 8'd0;
  logic m_pulse = 1'b0;
  logic [15:0] m_cap = 16'd0;

  always #4 clk = ~clk;

  beam_pos_counter u_dut (
    .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .wide_mode(wide_mode),
    .pal_mode(pal_mode), .disp_en(disp_en), .dbl_interlace(dbl_interlace),
    .hv_freeze(hv_freeze), .hv_capture(hv_capture), .hint_reload(hint_reload),
    .hpos(hpos), .vpos(vpos), .hblank(hblank), .vblank(vblank),
    .hint_pulse(hint_pulse), .hv_word(hv_word)
  );

  function automatic logic [15:0] exp_live();
    logic [7:0] lb;
    lb = dbl_interlace ? {m_v[6:0], m_v[7]} : m_v[7:0];
    return {lb, m_h};
  endfunction

  function automatic logic exp_hblank();
    return wide_mode ? (m_h > 8'd178) : (m_h > 8'd233);
  endfunction

  function automatic logic exp_vblank();
    logic [8:0] first_off;
    first_off = m_pal ? 9'd240 : 9'd224;
    return !disp_en || (m_v >= first_off && m_v < 9'd511);
  endfunction

  task automatic cmp(string tag, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cycles, act, exp);
    end
  endtask

  task automatic check_all();
    cmp("R1/R2/R3 hpos", {8'd0, hpos}, {8'd0, m_h});
    cmp("R4/R8 vpos", {7'd0, vpos}, {7'd0, m_v});
    cmp("R5 hblank", {15'd0, hblank}, {15'd0, exp_hblank()});
    cmp("R6 vblank", {15'd0, vblank}, {15'd0, exp_vblank()});
    cmp("R7 hint_pulse", {15'd0, hint_pulse}, {15'd0, m_pulse});
    cmp("R9/R10 hv_word", hv_word, hv_freeze ? m_cap : exp_live());
  endtask

  task automatic step();
    logic [7:0] nh, ncnt;
    logic [8:0] nv, first_off, last;
    logic lc, npal, npulse;
    logic [15:0] ncap;
    ncap = hv_capture ? exp_live() : m_cap;
    nh = m_h; nv = m_v; npal = m_pal; ncnt = m_cnt; npulse = 1'b0;
    if (slot_en) begin
      nh = m_h + 8'd1;
      if (wide_mode && nh == 8'd183) nh = 8'd229;
      if (!wide_mode && nh == 8'd148) nh = 8'd233;
      lc = wide_mode ? (nh == 8'd165) : (nh == 8'd132);
      last = m_pal ? 9'd312 : 9'd261;
      first_off = m_pal ? 9'd240 : 9'd224;
      if (lc) nv = (m_v == last) ? 9'd0 : m_v + 9'd1;
      if (m_h == 8'd0 && m_v == 9'd0) npal = pal_mode;
      if (lc) begin
        if (nv >= first_off) ncnt = hint_reload;
        else if (m_cnt != 8'd0) ncnt = m_cnt - 8'd1;
        else begin ncnt = hint_reload; npulse = 1'b1; end
      end
    end
    @(posedge clk);
    #2;
    m_h = nh; m_v = nv; m_pal = npal; m_cnt = ncnt; m_pulse = npulse; m_cap = ncap;
    check_all();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected under 190000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    // R1: reset state
    cmp("R1 reset hpos", {8'd0, hpos}, 16'd0);
    cmp("R1 reset vpos", {7'd0, vpos}, 16'd0);
    cmp("R1 reset hint_pulse", {15'd0, hint_pulse}, 16'd0);
    cmp("R1 reset hv_word", hv_word, 16'd0);
    rst_n = 1'b1;

    // R1: no slot, no motion
    slot_en = 1'b0;
    repeat (5) step();

    // R2 R4 R7: a whole NTSC wide frame
    slot_en = 1'b1;
    repeat (262 * 210) step();

    // R3 R8: switch to narrow PAL just before the frame start, with interlace encoding (R10)
    wide_mode = 1'b0; pal_mode = 1'b1; dbl_interlace = 1'b1; hint_reload = 8'd0;
    repeat (313 * 171 + 400) step();

    // R9: directed capture then freeze
    hv_capture = 1'b1; step();
    hv_capture = 1'b0; hv_freeze = 1'b1;
    repeat (50) step();
    hv_freeze = 1'b0;

    // random mix for all requirements
    for (int i = 0; i < 20000; i++) begin
      slot_en = ($urandom % 4) != 0;
      hv_capture = ($urandom % 64) == 0;
      if (($urandom % 256) == 0) hv_freeze = ~hv_freeze;
      if (($urandom % 512) == 0) disp_en = ~disp_en;
      if (($urandom % 512) == 0) dbl_interlace = ~dbl_interlace;
      if (($urandom % 3000) == 0) wide_mode = ~wide_mode;
      if (($urandom % 3000) == 0) pal_mode = ~pal_mode;
      if (($urandom % 1000) == 0) hint_reload = 8'($urandom % 8);
      step();
    end
    finish_run();
  end
endmodule